// File: doc/BRIEF.md
# Phase-Continuous FSK Tone Modulator

This block turns a serial NRZ bit stream into a stream of sample codes for an external DAC. The codes describe a trapezoidal carrier. A high data bit gives a 1200 Hz mark tone and a low data bit gives a 2200 Hz space tone. Everything runs from one 460.8 kHz master clock, so both tones scale exactly with that clock.

A phase accumulator advances on every master clock. The accumulator's modulus equals the clock rate in hertz and its increment equals the wanted tone frequency in hertz, so the average tone frequency is exact. A change of data bit only changes the increment and never touches the stored phase, so the waveform has no phase jump.

The shaper maps the phase onto four segments: a linear rise, a flat top, a linear fall and a flat base. This keeps the edge slope bounded. An active-low request-to-send gates the block. While it is inactive, the accumulator is held at phase zero and the output sits at a fixed idle code. A transmit-active flag is brought out so that the receive path can be switched off while the block is transmitting.

Top module: `fsk_modulator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the accumulator clears to phase zero, `tx_active` goes to 0 and `sample_code` goes to the idle code (default 0).
- R2: While `tx_active` is 0, `sample_code` on the following clock is the idle code, whatever `txd` does.
- R3: With `txd` held at 1, the output repeats exactly every 384 clocks (increment 1200 in a modulus of 460800).
- R4: With `txd` held at 0, the increment is 2200 and the output repeats exactly every 2304 clocks (11 space cycles, about 209.45 clocks each).
- R5: A change of `txd` changes only the increment. The phase continues from its current value, so the output stays on the reference waveform computed with continuous phase.
- R6: The output code for phase p, with modulus M=460800, ramp length L=M/8 and C=255, is: floor(p*C/L) for p<L; C for L<=p<4L; C-floor((p-4L)*C/L) for 4L<=p<5L; 0 otherwise.
- R7: Between two consecutive active output codes, the absolute difference is at most 10 (at most 11 is allowed in the assertion).
- R8: When `rts_n` falls, the first active code is phase 0 (code 0) and the phase then rises by the increment for the sampled bit.
- R9: `txd` sampled at edge k sets the increment applied at edge k+1, so it shows in `sample_code` at edge k+2.
- R10: `tx_active` equals the inverse of `rts_n` sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 460.8 kHz master clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rts_n | input | 1 | Request to send, active low |
| txd | input | 1 | NRZ transmit data bit (1 = mark, 0 = space) |
| tx_active | output | 1 | High while the modulator is transmitting |
| sample_code | output | CODE_W (8) | Trapezoidal waveform code for the DAC |

## Verification
Two events can land on the same clock: a change of data bit, and the accumulator wrapping past its modulus. The bench watches its own model. It changes `txd` on the exact cycle where the model's next step wraps, and compares the output on every clock against a reference with continuous phase. A second coincidence comes from dropping `rts_n` high in the middle of a ramp while the data bit also changes. This checks that the idle code takes priority and that the next burst restarts cleanly from phase zero.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

  typedef enum logic [1:0] {
    SEG_RISE = 2'd0,
    SEG_TOP  = 2'd1,
    SEG_FALL = 2'd2,
    SEG_BASE = 2'd3
  } fsk_seg_e;

  // increment selected by the current data bit
  function automatic int unsigned pick_increment(input logic mark,
                                                 input int unsigned mark_inc,
                                                 input int unsigned space_inc);
    return mark ? mark_inc : space_inc;
  endfunction

  // modular addition, assuming acc < modulus and inc < modulus
  function automatic int unsigned wrap_add(input int unsigned acc,
                                           input int unsigned inc,
                                           input int unsigned modulus);
    longint unsigned s;
    s = longint'(acc) + longint'(inc);
    if (s >= longint'(modulus)) s = s - longint'(modulus);
    return int'(s);
  endfunction

  // segment of the trapezoid a phase falls into
  function automatic fsk_seg_e seg_of(input int unsigned p,
                                      input int unsigned ramp,
                                      input int unsigned half);
    if (p < ramp)             return SEG_RISE;
    else if (p < half)        return SEG_TOP;
    else if (p < half + ramp) return SEG_FALL;
    else                      return SEG_BASE;
  endfunction

  // trapezoid level for a phase
  function automatic int unsigned trap_level(input int unsigned p,
                                             input int unsigned ramp,
                                             input int unsigned half,
                                             input int unsigned top);
    longint unsigned num;
    int unsigned     lvl;
    lvl = 0;
    case (seg_of(p, ramp, half))
      SEG_RISE: begin
        num = longint'(p) * longint'(top);
        lvl = int'(num / longint'(ramp));
      end
      SEG_TOP:  lvl = top;
      SEG_FALL: begin
        num = longint'(p - half) * longint'(top);
        lvl = top - int'(num / longint'(ramp));
      end
      default:  lvl = 0;
    endcase
    return lvl;
  endfunction

endpackage

// File: rtl/fsk_bit_sampler.sv
module fsk_bit_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic rts_n,
  input  logic txd,
  output logic en_q,
  output logic mark_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mark_q <= 1'b0;
    end else begin
      en_q   <= ~rts_n;
      mark_q <= txd;
    end
  end

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc
  import fsk_mod_pkg::*;
#(
  parameter int unsigned MODULUS   = 460800,
  parameter int unsigned MARK_INC  = 1200,
  parameter int unsigned SPACE_INC = 2200,
  parameter int unsigned ACC_W     = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mark,
  output logic [ACC_W-1:0] acc_q,
  output logic             wrap_evt
);

  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] inc_w;

  always_comb begin
    inc_w = ACC_W'(pick_increment(mark, MARK_INC, SPACE_INC));
    acc_d = ACC_W'(wrap_add(32'(acc_q), 32'(inc_w), MODULUS));
  end

  // the next phase lands below the present one only on a wrap
  assign wrap_evt = en & (acc_d < acc_q);

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (!en) acc_q <= '0;
    else          acc_q <= acc_d;
  end

endmodule

// File: rtl/fsk_shaper.sv
module fsk_shaper
  import fsk_mod_pkg::*;
#(
  parameter int unsigned MODULUS   = 460800,
  parameter int unsigned RAMP_DIV  = 8,
  parameter int unsigned ACC_W     = 19,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned IDLE_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [ACC_W-1:0]  phase,
  output logic [CODE_W-1:0] code_q,
  output fsk_seg_e          seg
);

  localparam int unsigned RAMP     = MODULUS / RAMP_DIV;
  localparam int unsigned HALF     = MODULUS / 2;
  localparam int unsigned CODE_TOP = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] level_w;

  always_comb begin
    seg     = seg_of(32'(phase), RAMP, HALF);
    level_w = CODE_W'(trap_level(32'(phase), RAMP, HALF, CODE_TOP));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   code_q <= CODE_W'(IDLE_CODE);
    else if (!en) code_q <= CODE_W'(IDLE_CODE);
    else          code_q <= level_w;
  end

endmodule

// File: rtl/fsk_modulator.sv
module fsk_modulator
  import fsk_mod_pkg::*;
#(
  parameter int unsigned CLK_HZ    = 460800,
  parameter int unsigned MARK_HZ   = 1200,
  parameter int unsigned SPACE_HZ  = 2200,
  parameter int unsigned RAMP_DIV  = 8,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned IDLE_CODE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rts_n,
  input  logic              txd,
  output logic              tx_active,
  output logic [CODE_W-1:0] sample_code
);

  localparam int unsigned ACC_W = $clog2(CLK_HZ);

  logic             en_w;
  logic             mark_w;
  logic [ACC_W-1:0] acc_w;
  logic             wrap_evt_w;
  fsk_seg_e         seg_w;

  fsk_bit_sampler u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .rts_n  (rts_n),
    .txd    (txd),
    .en_q   (en_w),
    .mark_q (mark_w)
  );

  fsk_phase_acc #(
    .MODULUS   (CLK_HZ),
    .MARK_INC  (MARK_HZ),
    .SPACE_INC (SPACE_HZ),
    .ACC_W     (ACC_W)
  ) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_w),
    .mark     (mark_w),
    .acc_q    (acc_w),
    .wrap_evt (wrap_evt_w)
  );

  fsk_shaper #(
    .MODULUS   (CLK_HZ),
    .RAMP_DIV  (RAMP_DIV),
    .ACC_W     (ACC_W),
    .CODE_W    (CODE_W),
    .IDLE_CODE (IDLE_CODE)
  ) u_shape (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en_w),
    .phase  (acc_w),
    .code_q (sample_code),
    .seg    (seg_w)
  );

  assign tx_active = en_w;

endmodule

// File: rtl/fsk_modulator_chk.sv
module fsk_modulator_chk #(
  parameter int unsigned CLK_HZ    = 460800,
  parameter int unsigned SPACE_HZ  = 2200,
  parameter int unsigned RAMP_DIV  = 8,
  parameter int unsigned CODE_W    = 8,
  parameter int unsigned IDLE_CODE = 0,
  parameter int unsigned ACC_W     = 19
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rts_n,
  input logic              tx_active,
  input logic [CODE_W-1:0] sample_code,
  input logic [ACC_W-1:0]  acc,
  input logic              wrap_evt
);

  localparam int unsigned RAMP     = CLK_HZ / RAMP_DIV;
  localparam int unsigned CODE_TOP = (1 << CODE_W) - 1;
  localparam int unsigned MAX_STEP = (SPACE_HZ * CODE_TOP + RAMP - 1) / RAMP + 1;

  function automatic int unsigned gap(input logic [CODE_W-1:0] a,
                                      input logic [CODE_W-1:0] b);
    return (a > b) ? 32'(a - b) : 32'(b - a);
  endfunction

  assert_idle_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> (sample_code == CODE_W'(IDLE_CODE)));

  assert_enable_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n == 1'b0) |=> tx_active);

  assert_disable_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n == 1'b1) |=> !tx_active);

  assert_phase_parks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_active |=> (acc == '0));

  assert_phase_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |=> (acc != $past(acc)));

  assert_wrap_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (32'(acc) < SPACE_HZ));

  assert_slope_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tx_active) && $past(tx_active, 2)) |->
      (gap(sample_code, $past(sample_code)) <= MAX_STEP));

endmodule

bind fsk_modulator fsk_modulator_chk #(
  .CLK_HZ    (CLK_HZ),
  .SPACE_HZ  (SPACE_HZ),
  .RAMP_DIV  (RAMP_DIV),
  .CODE_W    (CODE_W),
  .IDLE_CODE (IDLE_CODE),
  .ACC_W     (ACC_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rts_n       (rts_n),
  .tx_active   (tx_active),
  .sample_code (sample_code),
  .acc         (acc_w),
  .wrap_evt    (wrap_evt_w)
);

// File: tb/fsk_modulator_tb_top.sv
`timescale 1ns/1ps
module fsk_modulator_tb_top;

  localparam int MODV = 460800;
  localparam int LEN  = MODV / 8;
  localparam int TOPC = 255;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rts_n = 1'b1;
  logic       txd = 1'b0;
  logic       tx_active;
  logic [7:0] sample_code;

  int n_vec = 0;
  int n_bad = 0;
  int cyc = 0;

  // reference model state
  int m_en = 0, m_d = 0, m_acc = 0, m_code = 0;
  int prev_code = 0;
  int prev_act = 0;
  int hist[$];

  fsk_modulator dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rts_n       (rts_n),
    .txd         (txd),
    .tx_active   (tx_active),
    .sample_code (sample_code)
  );

  always #5 clk = ~clk;

  function automatic int ref_level(int p);
    int k;
    k = p / LEN;
    if (k == 0) return (p * TOPC) / LEN;
    if (k < 4)  return TOPC;
    if (k == 4) return TOPC - ((p - 4 * LEN) * TOPC) / LEN;
    return 0;
  endfunction

  always @(posedge clk) begin
    int ncode, nacc;
    cyc++;
    if (!rst_n) begin
      m_en = 0; m_d = 0; m_acc = 0; m_code = 0;
    end else begin
      ncode = m_en ? ref_level(m_acc) : 0;
      nacc  = m_en ? (m_acc + (m_d ? 1200 : 2200)) % MODV : 0;
      m_en = !rts_n; m_d = txd; m_acc = nacc; m_code = ncode;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // every-clock comparison against the model (R6 shape, R5/R9 phase, R10 flag)
  always @(negedge clk) begin
    check(int'(sample_code) == m_code, "R6", int'(sample_code), m_code);
    check(int'(tx_active) == m_en, "R10", int'(tx_active), m_en);
    if (prev_act && m_en && rst_n) begin
      int d;
      d = int'(sample_code) - prev_code;
      if (d < 0) d = -d;
      check(d <= 10, "R7", d, 10);
    end
    prev_act = (m_en != 0) && tx_active;
    prev_code = int'(sample_code);
    hist.push_back(int'(sample_code));
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #20_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int base;
    logic [7:0] lfsr;
    @(negedge clk);
    tick(4);
    check(sample_code == 8'd0, "R1", int'(sample_code), 0);
    check(tx_active == 1'b0, "R1", int'(tx_active), 0);
    rst_n = 1'b1;

    // idle with data toggling: output stays at idle code
    for (int i = 0; i < 20; i++) begin
      txd = i[0];
      tick(1);
      check(sample_code == 8'd0, "R2", int'(sample_code), 0);
    end

    // start mark burst
    txd = 1'b1; rts_n = 1'b0;
    tick(1);
    check(tx_active == 1'b1, "R10", int'(tx_active), 1);
    tick(1);
    check(sample_code == 8'd0, "R8", int'(sample_code), 0);
    tick(1);
    check(int'(sample_code) == (1200 * 255) / LEN, "R8", int'(sample_code), (1200 * 255) / LEN);
    base = hist.size();
    tick(900);
    for (int i = 0; i < 400; i++)
      check(hist[base + i] == hist[base + i + 384], "R3", hist[base + i + 384], hist[base + i]);

    // space tone; R9: the switch shows two edges after sampling
    txd = 1'b0;
    tick(10);
    base = hist.size();
    tick(2700);
    for (int i = 0; i < 300; i++)
      check(hist[base + i] == hist[base + i + 2304], "R4", hist[base + i + 2304], hist[base + i]);

    // pseudo-random bits at the bit rate, R5 judged by the model compare
    lfsr = 8'hA5;
    for (int b = 0; b < 24; b++) begin
      txd = lfsr[0];
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      tick(384);
    end

    // R5: flip data on the cycle the model's next step wraps
    for (int k = 0; k < 4; k++) begin
      while (!(m_en != 0 && m_acc + (m_d ? 1200 : 2200) >= MODV)) tick(1);
      txd = ~txd;
      tick(30);
    end

    // R2: drop request mid-ramp with data change in the same cycle
    while (!(m_acc > 1000 && m_acc < LEN / 2)) tick(1);
    rts_n = 1'b1; txd = ~txd;
    tick(2);
    check(sample_code == 8'd0, "R2", int'(sample_code), 0);
    tick(5);
    rts_n = 1'b0;
    tick(400);

    // R1: reset while active
    rst_n = 1'b0;
    tick(1);
    check(sample_code == 8'd0, "R1", int'(sample_code), 0);
    check(tx_active == 1'b0, "R1", int'(tx_active), 0);
    rst_n = 1'b1;
    tick(300);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule